// File: doc/BRIEF.md
# Input Level-Width Measurement Channel

This block is a single timer channel that measures how long an input signal stays at one chosen level. Software arms the channel with a one-cycle start trigger. The channel then waits, without counting, for the edge that enters the chosen level. That edge clears the counter to zero. The counter then advances on every cycle in which the external prescaler tick is high. On the edge that leaves the chosen level, the channel latches the count into a capture register, pulses an interrupt for one cycle and rewrites an overflow flag. The counter then freezes until the next entering edge, so successive widths are measured with no further software action.

A one-cycle stop trigger disarms the channel and freezes the counter and the overflow flag. The level-select bit can only be written while the channel is disarmed. The live counter, the capture register, the enable status and the overflow flag are always visible on the ports. The input pin is asynchronous and passes through a synchronizer inside the block.

Top module: `pwm_meas`

## Requirements
- R1: A start pulse (`start_i`=1 with `stop_i`=0) sets `en_o` to 1 in the next cycle and puts the channel in a waiting state in which `cnt_o` does not change, whatever the tick does.
- R2: A stop pulse clears `en_o` in the next cycle and freezes `cnt_o` and `ovf_o`. When `stop_i` and `start_i` are both high, stop wins.
- R3: The start edge clears `cnt_o` to 0. A pin change that arrives before clock edge k takes effect at edge k+2. After that, `cnt_o` increments by one at each edge where `tick_i` is 1 and holds where `tick_i` is 0.
- R4: On the capture edge, `cap_o` takes the value `cnt_o` had just before that edge, and `irq_o` is high for exactly one cycle. The counter does not increment at the capture edge itself.
- R5: At each capture, `ovf_o` becomes 1 if the counter wrapped from all-ones to zero at any point since that measurement's start edge, and 0 otherwise. The captured value is the count modulo 2^16.
- R6: After a capture, `cnt_o` holds the captured value until the next start edge, and the next start edge begins a new measurement with no new start pulse.
- R7: With `cfg_low_o`=0 the channel measures high time (rising edge starts, falling edge captures). With `cfg_low_o`=1 it measures low time (falling edge starts, rising edge captures).
- R8: `cfg_wr_i` loads `cfg_low_i` into `cfg_low_o` only while `en_o` is 0. While `en_o` is 1 the write is ignored.
- R9: After reset, `cnt_o`, `cap_o`, `ovf_o`, `en_o`, `irq_o` and `cfg_low_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable tick from the prescaler |
| pin_i | input | 1 | Asynchronous measured input |
| cfg_wr_i | input | 1 | Write strobe for the level select |
| cfg_low_i | input | 1 | Level select write data (1 = low width) |
| start_i | input | 1 | Arm trigger, one cycle |
| stop_i | input | 1 | Disarm trigger, one cycle |
| cfg_low_o | output | 1 | Current level select |
| en_o | output | 1 | Channel enabled status |
| ovf_o | output | 1 | Overflow flag of the last capture |
| cnt_o | output | 16 | Live counter |
| cap_o | output | 16 | Captured width |
| irq_o | output | 1 | Capture interrupt pulse |

## Verification
A wrong controller state shows within one measurement. Either `irq_o` never pulses, or it pulses at the wrong edge, and `cap_o` then differs from the number of ticks the bench counted between the synchronized edges. A counter that keeps running when it should hold shows at once: `cnt_o` moves during waiting or disarmed periods, and it stops matching `cap_o` after a capture. An overflow-pending bit that is not cleared at each start edge is caught by the first short measurement that follows an overflowed one. Its `ovf_o` stays at 1 when it should be 0.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } meas_state_t;

  // Edge that opens a measurement for the selected level.
  function automatic logic open_edge(input logic low_sel, input logic rise, input logic fall);
    return low_sel ? fall : rise;
  endfunction

  // Edge that closes a measurement for the selected level.
  function automatic logic close_edge(input logic low_sel, input logic rise, input logic fall);
    return low_sel ? rise : fall;
  endfunction

  // True when an increment from this value wraps to zero.
  function automatic logic will_wrap(input logic [15:0] value);
    return &value;
  endfunction

endpackage

// File: rtl/pwm_meas_sync.sv
module pwm_meas_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else if (g == 0) sh_q[g] <= pin_i;
        else sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sh_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pwm_meas_ctrl.sv
module pwm_meas_ctrl
  import pwm_meas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic cfg_wr_i,
  input  logic cfg_low_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic open_evt_o,
  output logic close_evt_o,
  output logic run_o,
  output logic en_o,
  output logic cfg_low_o
);

  meas_state_t state_q, state_d;
  logic        trig;

  assign trig        = start_i | stop_i;
  assign open_evt_o  = (state_q == ST_WAIT) && !trig && open_edge(cfg_low_o, rise_i, fall_i);
  assign close_evt_o = (state_q == ST_RUN)  && !trig && close_edge(cfg_low_o, rise_i, fall_i);
  assign run_o       = (state_q == ST_RUN)  && !trig;

  always_comb begin
    state_d = state_q;
    if (stop_i)            state_d = ST_OFF;
    else if (start_i)      state_d = ST_WAIT;
    else if (open_evt_o)   state_d = ST_RUN;
    else if (close_evt_o)  state_d = ST_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      en_o      <= 1'b0;
      cfg_low_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (stop_i)       en_o <= 1'b0;
      else if (start_i) en_o <= 1'b1;
      if (cfg_wr_i && !en_o) cfg_low_o <= cfg_low_i;
    end
  end

endmodule

// File: rtl/pwm_meas_count.sv
module pwm_meas_count
  import pwm_meas_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             open_evt_i,
  input  logic             close_evt_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             ovf_o,
  output logic             irq_o
);

  logic pend_q;
  logic inc;

  assign inc = run_i && tick_i && !close_evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      cap_o  <= '0;
      ovf_o  <= 1'b0;
      irq_o  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_o <= close_evt_i;
      if (open_evt_i) begin
        cnt_o  <= '0;
        pend_q <= 1'b0;
      end else if (close_evt_i) begin
        cap_o <= cnt_o;
        ovf_o <= pend_q;
      end else if (inc) begin
        cnt_o <= cnt_o + 1'b1;
        if (&cnt_o) pend_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_meas.sv
module pwm_meas #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_low_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             cfg_low_o,
  output logic             en_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o
);

  logic rise_w, fall_w;
  logic open_evt_w, close_evt_w, run_w;

  pwm_meas_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise_w), .fall_o(fall_w)
  );

  pwm_meas_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cfg_wr_i(cfg_wr_i), .cfg_low_i(cfg_low_i), .rise_i(rise_w), .fall_i(fall_w),
    .open_evt_o(open_evt_w), .close_evt_o(close_evt_w), .run_o(run_w),
    .en_o(en_o), .cfg_low_o(cfg_low_o)
  );

  pwm_meas_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .open_evt_i(open_evt_w),
    .close_evt_i(close_evt_w), .run_i(run_w), .cnt_o(cnt_o), .cap_o(cap_o),
    .ovf_o(ovf_o), .irq_o(irq_o)
  );

endmodule

// File: rtl/pwm_meas_chk.sv
module pwm_meas_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             cfg_wr_i,
  input logic             open_evt_w,
  input logic             close_evt_w,
  input logic             run_w,
  input logic             en_o,
  input logic             cfg_low_o,
  input logic             ovf_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             irq_o
);

  // R1: arming sets the enable status
  a_r1_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> en_o);

  // R2: disarm wins and freezes the overflow flag
  a_r2_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!en_o && $stable(ovf_o)));

  // R3: opening edge zeroes the counter
  a_r3_open_clear: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt_w |=> (cnt_o == '0));

  // R4: capture latches the prior count and raises the interrupt
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt_w |=> (irq_o && cap_o == $past(cnt_o)));

  // R4: the interrupt lasts one cycle
  a_r4_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R6: no counter movement outside a measurement
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_w && !open_evt_w) |=> $stable(cnt_o));

  // R8: level select is locked while enabled
  a_r8_cfg_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && cfg_wr_i) |=> $stable(cfg_low_o));

endmodule

bind pwm_meas pwm_meas_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .cfg_wr_i(cfg_wr_i),
  .open_evt_w(open_evt_w), .close_evt_w(close_evt_w), .run_w(run_w),
  .en_o(en_o), .cfg_low_o(cfg_low_o), .ovf_o(ovf_o), .cnt_o(cnt_o),
  .cap_o(cap_o), .irq_o(irq_o)
);

// File: tb/test_pwm_meas.sv
module test_pwm_meas;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, pin_i = 1'b0, cfg_wr_i = 1'b0, cfg_low_i = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic        cfg_low_o, en_o, ovf_o, irq_o;
  logic [15:0] cnt_o, cap_o;

  int n_run = 0, n_fail = 0, irq_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_meas i_pwm_meas (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i), .cfg_wr_i(cfg_wr_i),
    .cfg_low_i(cfg_low_i), .start_i(start_i), .stop_i(stop_i), .cfg_low_o(cfg_low_o),
    .en_o(en_o), .ovf_o(ovf_o), .cnt_o(cnt_o), .cap_o(cap_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (rst_n && irq_o) irq_seen++;

  function automatic logic [15:0] ref_cap(input longint ticks);
    return 16'(ticks % 65536);
  endfunction

  function automatic logic ref_ovf(input longint ticks);
    return ticks >= 65536;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // One measurement: pin at active level before edges 0..w-1.
  // Counting edges are 3..w+1, capture at edge w+2.
  task automatic measure(input logic low, input int w, input bit full, output longint ticks);
    ticks = 0;
    for (int i = 0; i < w + 4; i++) begin
      @(negedge clk);
      pin_i  = (i < w) ? ~low : low;
      tick_i = full ? 1'b1 : 1'($urandom % 2);
      if (i >= 3 && i <= w + 1 && tick_i) ticks++;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    longint t;
    int irq0;
    logic [15:0] snap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 cnt", cnt_o, 0); check("R9 cap", cap_o, 0); check("R9 ovf", ovf_o, 0);
    check("R9 en", en_o, 0);   check("R9 irq", irq_o, 0); check("R9 cfg", cfg_low_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 arm: waiting, no counting
    pulse_start();
    check("R1 en", en_o, 1);
    tick_i = 1'b1; repeat (10) @(negedge clk); tick_i = 1'b0;
    check("R1 wait no count", cnt_o, 0);

    // R8 write ignored while enabled
    @(negedge clk) begin cfg_wr_i = 1'b1; cfg_low_i = 1'b1; end
    @(negedge clk) cfg_wr_i = 1'b0;
    check("R8 locked", cfg_low_o, 0);

    // R3/R4/R7 directed high width, all ticks
    irq0 = irq_seen;
    measure(1'b0, 10, 1'b1, t);
    check("R3 R4 cap directed", cap_o, ref_cap(t));
    check("R4 irq once", irq_seen - irq0, 1);
    check("R5 no ovf", ovf_o, ref_ovf(t));

    // R6 holds, rearms by itself, random ticks
    for (int k = 0; k < 6; k++) begin
      int w = 5 + int'($urandom % 60);
      irq0 = irq_seen;
      measure(1'b0, w, 1'b0, t);
      check("R3 cap random high", cap_o, ref_cap(t));
      check("R4 irq random", irq_seen - irq0, 1);
      tick_i = 1'b1; repeat (5) @(negedge clk); tick_i = 1'b0;
      check("R6 hold after capture", cnt_o, cap_o);
    end

    // R2 stop, then R8 writable, R7 low width
    pulse_stop();
    check("R2 en cleared", en_o, 0);
    @(negedge clk) begin cfg_wr_i = 1'b1; cfg_low_i = 1'b1; end
    @(negedge clk) cfg_wr_i = 1'b0;
    check("R8 write when disabled", cfg_low_o, 1);
    pin_i = 1'b1; repeat (4) @(negedge clk);
    pulse_start();
    for (int k = 0; k < 4; k++) begin
      irq0 = irq_seen;
      measure(1'b1, 4 + int'($urandom % 40), 1'b0, t);
      check("R7 cap low width", cap_o, ref_cap(t));
      check("R7 irq low width", irq_seen - irq0, 1);
    end

    // R5 overflow with low width
    measure(1'b1, 65540, 1'b1, t);
    check("R5 ovf set", ovf_o, 1);
    check("R5 cap wrapped", cap_o, ref_cap(t));

    // R2 stop mid-measurement holds count and ovf
    @(negedge clk) begin pin_i = 1'b0; tick_i = 1'b1; end
    repeat (12) @(negedge clk);
    stop_i = 1'b1; start_i = 1'b1;
    @(negedge clk) begin stop_i = 1'b0; start_i = 1'b0; end
    snap = cnt_o;
    check("R2 stop wins", en_o, 0);
    repeat (10) @(negedge clk);
    tick_i = 1'b0;
    check("R2 cnt frozen", cnt_o, snap);
    check("R2 count advanced before stop", snap != 0, 1);
    check("R2 ovf held", ovf_o, 1);

    // R5 cleared on next clean capture
    pin_i = 1'b1; repeat (4) @(negedge clk);
    pulse_start();
    measure(1'b1, 20, 1'b0, t);
    check("R5 ovf cleared", ovf_o, 0);
    check("R5 cap clean", cap_o, ref_cap(t));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule